// File: doc/BRIEF.md
# Interrupt Pending State Controller

This block holds the pending state of every interrupt line in a small interrupt distributor. Each line has one stored pending latch, a registered copy of its input level and a trigger-type bit that marks it as edge or level sensitive. The latch can be set by a hardware rising edge or by a software write. It can be cleared by a software write or by an acknowledge from the CPU interface. The pending value that the block reports is the latch, ORed with the live line for level-sensitive interrupts. A level interrupt therefore stays pending for as long as its source holds the line high, whatever software does to the latch.

Software sees two byte-wide windows: a set window and a clear window. In both, byte offset k, bit j maps to interrupt 8k+j. Reads from either window return the reported pending value. The pending vector on `pend_out` feeds downstream arbitration. A mode input selects a legacy scheme. In that scheme every rising edge latches, regardless of trigger type, and the reported value is the latch alone.

Top module: `irq_pend_ctrl`

## Requirements
- R1: While `rst` is high, at each clock edge every latch is cleared, every recorded level is cleared, every trigger bit is set to edge, and `reg_rdata` is set to 0. In the cycle after reset, `pend_out` is all zeros.
- R2: When `legacy_mode` is 0, an interrupt whose trigger bit is 0 (level) and whose line has been sampled high is reported pending, even with its latch clear. It stops being reported pending once its line is sampled low, unless its latch is set.
- R3: When `legacy_mode` is 0 and the trigger bit is 1 (edge), a rising edge of the line sets the latch. A falling edge leaves the latch unchanged.
- R4: An acknowledge (`ack_valid` with `ack_id` below NUM_IRQ) clears that interrupt's latch. A level interrupt whose line is still high remains reported pending.
- R5: A write to the set window (offset 0x200 + k) sets the latch of interrupt 8k+j for each 1 in bit j of `reg_wdata`. A write to the clear window (offset 0x280 + k) clears those latches. Bits written as 0 change nothing. A clear does not remove the pending state of a level line that is held high.
- R6: Set-window bits that map to interrupt IDs 0 to 15 have no effect. ID 16 is the lowest ID that a set write can pend.
- R7: Writes to bits that map to IDs at or above NUM_IRQ have no effect. A read returns 0 for such bits, and returns 0 for any offset outside both windows.
- R8: A read (`reg_re`) of either window returns, in `reg_rdata` one cycle later, the reported pending bits of the eight interrupts at that offset. Bit j holds interrupt 8k+j.
- R9: When `legacy_mode` is 1, any rising edge sets the latch, and the reported pending value is the latch alone. After an acknowledge, the interrupt pends again only on a new rising edge.
- R10: If a software set and an acknowledge hit the same interrupt in one cycle, the latch ends clear. If a hardware rising edge that latches coincides with an acknowledge, the latch ends set.
- R11: A pulse on `cfg_we` loads all trigger bits from `trig_edge_cfg`, where 1 means edge and 0 means level. The new types govern the following cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | 1 selects the legacy latch-only pending scheme |
| irq_in | input | NUM_IRQ | Raw interrupt lines, bit i is interrupt i |
| cfg_we | input | 1 | Load trigger types |
| trig_edge_cfg | input | NUM_IRQ | Trigger types to load, 1 = edge |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | ID_W | Interrupt ID being acknowledged |
| reg_we | input | 1 | Byte write strobe |
| reg_re | input | 1 | Byte read strobe |
| reg_addr | input | ADDR_W | Byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_re` |
| pend_out | output | NUM_IRQ | Reported pending vector |

## Verification
A wrong latch value cannot stay hidden behind a level line for long. When the line drops, or when legacy mode is selected, the latch alone drives `pend_out`, and any error appears there one clock after the change. Because of this, the bench drops lines after each clear and acknowledge before it checks the result. A wrong recorded level or trigger bit shows at once as a missing or extra pending bit in the cycle after the line changes. A wrong offset-to-ID mapping shows both in which `pend_out` bit moves after a write and in the read byte that comes back one cycle after `reg_re`.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
  // Byte offsets of the two software windows
  localparam int SET_WIN_BASE = 'h200;
  localparam int CLR_WIN_BASE = 'h280;
  // IDs below this cannot be pended through the set window
  localparam int SW_GEN_IDS   = 16;

  function automatic int bytes_for(input int n);
    return (n + 7) / 8;
  endfunction
endpackage

// File: rtl/irq_line_sampler.sv
module irq_line_sampler #(
  parameter int NUM_IRQ = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic [NUM_IRQ-1:0] lvl_q,
  output logic [NUM_IRQ-1:0] rise_vec
);
  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= irq_in;
  end

  assign rise_vec = irq_in & ~lvl_q;
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_pend_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W  = 12,
  parameter int ID_W    = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_we,
  input  logic               reg_re,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [7:0]         reg_wdata,
  input  logic               ack_valid,
  input  logic [ID_W-1:0]    ack_id,
  input  logic [NUM_IRQ-1:0] eff_pend,
  output logic [NUM_IRQ-1:0] sw_set,
  output logic [NUM_IRQ-1:0] sw_clr,
  output logic [NUM_IRQ-1:0] ack_hit,
  output logic [7:0]         reg_rdata
);
  localparam int NBYTES = bytes_for(NUM_IRQ);
  localparam int BIDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int PAD_W  = NBYTES * 8;

  logic [ADDR_W-1:0] set_off, clr_off, rd_off;
  logic              set_hit, clr_hit;
  logic [BIDX_W-1:0] rd_idx;
  logic [PAD_W-1:0]  eff_pad;

  assign set_off = reg_addr - ADDR_W'(SET_WIN_BASE);
  assign clr_off = reg_addr - ADDR_W'(CLR_WIN_BASE);
  assign set_hit = (reg_addr >= ADDR_W'(SET_WIN_BASE)) && (set_off < ADDR_W'(NBYTES));
  assign clr_hit = (reg_addr >= ADDR_W'(CLR_WIN_BASE)) && (clr_off < ADDR_W'(NBYTES));

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_dec
    if (i < SW_GEN_IDS) begin : g_sgi
      assign sw_set[i] = 1'b0;
    end else begin : g_norm
      assign sw_set[i] = reg_we && set_hit && (set_off == ADDR_W'(i / 8)) && reg_wdata[i % 8];
    end
    assign sw_clr[i]  = reg_we && clr_hit && (clr_off == ADDR_W'(i / 8)) && reg_wdata[i % 8];
    assign ack_hit[i] = ack_valid && (ack_id == ID_W'(i));
  end

  if (PAD_W > NUM_IRQ) begin : g_pad
    assign eff_pad = {{(PAD_W - NUM_IRQ){1'b0}}, eff_pend};
  end else begin : g_nopad
    assign eff_pad = eff_pend;
  end

  assign rd_off = set_hit ? set_off : clr_off;
  assign rd_idx = rd_off[BIDX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= 8'h00;
    end else if (reg_re) begin
      if (set_hit || clr_hit) reg_rdata <= eff_pad[{rd_idx, 3'b000} +: 8];
      else                    reg_rdata <= 8'h00;
    end
  end
endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int NUM_IRQ = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [NUM_IRQ-1:0] trig_edge_cfg,
  input  logic [NUM_IRQ-1:0] hw_set,
  input  logic [NUM_IRQ-1:0] sw_set,
  input  logic [NUM_IRQ-1:0] sw_clr,
  input  logic [NUM_IRQ-1:0] ack_hit,
  output logic [NUM_IRQ-1:0] latch_q,
  output logic [NUM_IRQ-1:0] trig_q
);
  always_ff @(posedge clk) begin
    if (rst)         trig_q <= '1;
    else if (cfg_we) trig_q <= trig_edge_cfg;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_latch
    always_ff @(posedge clk) begin
      if (rst) latch_q[i] <= 1'b0;
      else     latch_q[i] <= ((latch_q[i] | sw_set[i]) & ~(sw_clr[i] | ack_hit[i])) | hw_set[i];
    end
  end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl #(
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W  = 12,
  parameter int ID_W    = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               legacy_mode,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               cfg_we,
  input  logic [NUM_IRQ-1:0] trig_edge_cfg,
  input  logic               ack_valid,
  input  logic [ID_W-1:0]    ack_id,
  input  logic               reg_we,
  input  logic               reg_re,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic [NUM_IRQ-1:0] pend_out
);
  logic [NUM_IRQ-1:0] lvl_q, rise_vec, hw_set;
  logic [NUM_IRQ-1:0] sw_set, sw_clr, ack_hit;
  logic [NUM_IRQ-1:0] latch_q, trig_q;

  irq_line_sampler #(.NUM_IRQ(NUM_IRQ)) u_samp (
    .clk(clk), .rst(rst), .irq_in(irq_in), .lvl_q(lvl_q), .rise_vec(rise_vec)
  );

  // Legacy: any rising edge latches; otherwise only edge-typed lines
  assign hw_set = rise_vec & (legacy_mode ? {NUM_IRQ{1'b1}} : trig_q);

  irq_latch_bank #(.NUM_IRQ(NUM_IRQ)) u_bank (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .trig_edge_cfg(trig_edge_cfg),
    .hw_set(hw_set), .sw_set(sw_set), .sw_clr(sw_clr), .ack_hit(ack_hit),
    .latch_q(latch_q), .trig_q(trig_q)
  );

  // Reported pending: built only from flops and the mode input
  assign pend_out = legacy_mode ? latch_q : (latch_q | (~trig_q & lvl_q));

  irq_reg_port #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_port (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .ack_valid(ack_valid), .ack_id(ack_id),
    .eff_pend(pend_out), .sw_set(sw_set), .sw_clr(sw_clr), .ack_hit(ack_hit),
    .reg_rdata(reg_rdata)
  );
endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk #(
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W  = 12,
  parameter int ID_W    = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               legacy_mode,
  input logic               cfg_we,
  input logic [NUM_IRQ-1:0] trig_edge_cfg,
  input logic               ack_valid,
  input logic [ID_W-1:0]    ack_id,
  input logic               reg_re,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [7:0]         reg_rdata,
  input logic [NUM_IRQ-1:0] pend_out,
  input logic [NUM_IRQ-1:0] rise_vec,
  input logic [NUM_IRQ-1:0] latch_q,
  input logic [NUM_IRQ-1:0] trig_q
);
  logic [NUM_IRQ-1:0] ack_oh, latch_rise;
  logic               ack_in_range, out_of_win;

  assign ack_in_range = ack_valid && (ack_id < ID_W'(NUM_IRQ));
  assign ack_oh       = ack_in_range ? (NUM_IRQ'(1) << ack_id) : '0;
  assign latch_rise   = rise_vec & (legacy_mode ? {NUM_IRQ{1'b1}} : trig_q);
  assign out_of_win   = (reg_addr < ADDR_W'('h200)) ||
                        (reg_addr >= ADDR_W'('h280 + (NUM_IRQ + 7) / 8));

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (pend_out == '0 && reg_rdata == 8'h00));

  // R3
  rise_latches_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((latch_q & $past(latch_rise)) == $past(latch_rise)));

  // R4
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    ack_in_range |=> ((latch_q & $past(ack_oh & ~latch_rise)) == '0));

  // R9
  legacy_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (legacy_mode && ack_in_range) |=> (!legacy_mode || ((pend_out & $past(ack_oh & ~rise_vec)) == '0)));

  // R7
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_re && out_of_win) |=> (reg_rdata == 8'h00));

  // R11
  cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (trig_q == $past(trig_edge_cfg)));
endmodule

bind irq_pend_ctrl irq_pend_chk #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .legacy_mode(legacy_mode), .cfg_we(cfg_we),
  .trig_edge_cfg(trig_edge_cfg), .ack_valid(ack_valid), .ack_id(ack_id),
  .reg_re(reg_re), .reg_addr(reg_addr), .reg_rdata(reg_rdata), .pend_out(pend_out),
  .rise_vec(rise_vec), .latch_q(latch_q), .trig_q(trig_q)
);

// File: tb/irq_pend_ctrl_tb.sv
module irq_pend_ctrl_tb;
  localparam int N  = 64;
  localparam int AW = 12;
  localparam int IW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          legacy_mode = 1'b0;
  logic [N-1:0]  irq_in = '0;
  logic          cfg_we = 1'b0;
  logic [N-1:0]  trig_edge_cfg = '0;
  logic          ack_valid = 1'b0;
  logic [IW-1:0] ack_id = '0;
  logic          reg_we = 1'b0;
  logic          reg_re = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [N-1:0]  pend_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [N-1:0] exp_p = '0;
  logic [N-1:0] base_cfg = {{32{1'b1}}, {32{1'b0}}};

  always #4 clk = ~clk;

  irq_pend_ctrl #(.NUM_IRQ(N), .ADDR_W(AW), .ID_W(IW)) u_dut (
    .clk(clk), .rst(rst), .legacy_mode(legacy_mode), .irq_in(irq_in),
    .cfg_we(cfg_we), .trig_edge_cfg(trig_edge_cfg), .ack_valid(ack_valid),
    .ack_id(ack_id), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pend_out(pend_out)
  );

  task automatic chk_pend(input string req);
    n_chk++;
    if (pend_out !== exp_p) begin
      n_bad++;
      $display("FAIL %s pend_out act=%h exp=%h", req, pend_out, exp_p);
    end
  endtask

  task automatic chk_byte(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s rdata act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic line(input int id, input logic v);
    @(negedge clk); irq_in[id] = v;
    @(negedge clk);
  endtask

  task automatic ack(input int id);
    @(negedge clk); ack_valid = 1'b1; ack_id = IW'(id);
    @(negedge clk); ack_valid = 1'b0;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [7:0] exp);
    @(negedge clk); reg_re = 1'b1; reg_addr = AW'(a);
    @(negedge clk); reg_re = 1'b0;
    chk_byte(req, reg_rdata, exp);
  endtask

  task automatic load_cfg(input logic [N-1:0] c);
    @(negedge clk); cfg_we = 1'b1; trig_edge_cfg = c;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    chk_pend("R1");
    chk_byte("R1", reg_rdata, 8'h00);
  endtask

  task automatic t_level;
    line(20, 1'b1); exp_p[20] = 1'b1; chk_pend("R2");
    rd_chk("R8", 'h202, 8'h10);
    rd_chk("R8", 'h282, 8'h10);
    wr('h282, 8'h10); chk_pend("R5");
    line(20, 1'b0); exp_p[20] = 1'b0; chk_pend("R2");
    wr('h202, 8'h10); exp_p[20] = 1'b1; chk_pend("R5");
    line(20, 1'b1);
    ack(20); chk_pend("R4");
    line(20, 1'b0); exp_p[20] = 1'b0; chk_pend("R4");
  endtask

  task automatic t_edge;
    line(40, 1'b1); exp_p[40] = 1'b1; chk_pend("R3");
    line(40, 1'b0); chk_pend("R3");
    ack(40); exp_p[40] = 1'b0; chk_pend("R4");
    @(negedge clk); irq_in[40] = 1'b1; ack_valid = 1'b1; ack_id = IW'(40);
    @(negedge clk); ack_valid = 1'b0;
    exp_p[40] = 1'b1; chk_pend("R10");
    line(40, 1'b0); chk_pend("R10");
    ack(40); exp_p[40] = 1'b0; chk_pend("R4");
  endtask

  task automatic t_sgi;
    wr('h200, 8'hFF); wr('h201, 8'hFF); chk_pend("R6");
    wr('h202, 8'h01); exp_p[16] = 1'b1; chk_pend("R6");
    wr('h282, 8'h01); exp_p[16] = 1'b0; chk_pend("R5");
  endtask

  task automatic t_swbits;
    wr('h205, 8'h81); exp_p[40] = 1'b1; exp_p[47] = 1'b1; chk_pend("R5");
    wr('h285, 8'h01); exp_p[40] = 1'b0; chk_pend("R5");
    rd_chk("R8", 'h205, 8'h80);
  endtask

  task automatic t_range;
    wr('h208, 8'hFF); chk_pend("R7");
    wr('h288, 8'hFF); chk_pend("R7");
    rd_chk("R7", 'h208, 8'h00);
    rd_chk("R7", 'h300, 8'h00);
    rd_chk("R7", 'h1FF, 8'h00);
  endtask

  task automatic t_set_ack;
    @(negedge clk); reg_we = 1'b1; reg_addr = AW'('h205); reg_wdata = 8'h80;
    ack_valid = 1'b1; ack_id = IW'(47);
    @(negedge clk); reg_we = 1'b0; ack_valid = 1'b0;
    exp_p[47] = 1'b0; chk_pend("R10");
  endtask

  task automatic t_cfg;
    load_cfg(base_cfg | (N'(1) << 20));
    line(20, 1'b1); exp_p[20] = 1'b1; chk_pend("R11");
    line(20, 1'b0); chk_pend("R11");
    ack(20); exp_p[20] = 1'b0; chk_pend("R11");
    load_cfg(base_cfg);
  endtask

  task automatic t_legacy;
    @(negedge clk); legacy_mode = 1'b1;
    line(10, 1'b1); exp_p[10] = 1'b1; chk_pend("R9");
    ack(10); exp_p[10] = 1'b0; chk_pend("R9");
    line(10, 1'b0); chk_pend("R9");
    line(10, 1'b1); exp_p[10] = 1'b1; chk_pend("R9");
    ack(10); exp_p[10] = 1'b0; chk_pend("R9");
    @(negedge clk); legacy_mode = 1'b0;
    @(negedge clk); exp_p[10] = 1'b1; chk_pend("R2");
    line(10, 1'b0); exp_p[10] = 1'b0; chk_pend("R2");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    load_cfg(base_cfg); chk_pend("R11");
    t_level();
    t_edge();
    t_sgi();
    t_swbits();
    t_range();
    t_set_ack();
    t_cfg();
    t_legacy();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule